// File: doc/BRIEF.md
# Integrate-and-Fire Neuron Element

This block is the processing element of an event-driven spiking network accelerator. It keeps a signed membrane potential in a register. The potential moves only when the block is commanded to act on it. An external scheduler switches the element between two phases with one flag.

- In the accumulate phase, each cycle that carries an input spike adds a signed synaptic weight to the potential.
- In the evaluate phase, the element compares the potential against a programmable threshold. When the potential is strictly above the threshold, it raises a spike for one cycle and loads a programmable restart value.

There is no leak and no refractory period. Negative weights are accepted, so the element behaves like a rectified-linear unit. A synchronous clear zeroes the potential at each frame boundary.

Accumulation saturates at the two's-complement limits of the potential width instead of wrapping. Every control input is a plain level sampled on the rising clock edge. The element has no stream handshake: it accepts a new command on every cycle and cannot stall.

Top module: `ifn_neuron`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `vmem_o` is 0 and `spike_o` is 0.
- R2: With `mode_i`=1 (accumulate) and `spike_i`=1, the next `vmem_o` is the previous `vmem_o` plus `weight_i`, both read as signed two's-complement values of DATA_W bits (default 10).
- R3: With `mode_i`=1 and `spike_i`=0, `vmem_o` does not change, whatever `weight_i` holds.
- R4: With `mode_i`=0 (evaluate) and `vmem_o` strictly greater than `thresh_i`, `spike_o` is 1 on the next cycle and `vmem_o` takes the value of `reset_val_i`.
- R5: With `mode_i`=0 and `vmem_o` less than or equal to `thresh_i`, including equality, `spike_o` is 0 on the next cycle and `vmem_o` is kept.
- R6: An accumulation result above 2^(DATA_W-1)-1 is clamped to 2^(DATA_W-1)-1, and a result below -2^(DATA_W-1) is clamped to -2^(DATA_W-1).
- R7: `spike_o` is 1 only in the cycle that follows an evaluate-phase cycle that fired, so a spike lasts exactly one cycle. An accumulate-phase cycle never sets it.
- R8: `clr_i`=1 forces `vmem_o` to 0 and `spike_o` to 0 on the next cycle. It overrides both phases.
- R9: The threshold comparison is signed, so negative potentials and negative thresholds compare correctly.
- R10: The restart value is the current `reset_val_i`, which may be zero (the normal setting) or any signed value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous frame clear of the potential |
| mode_i | input | 1 | Phase select: 1 = accumulate, 0 = evaluate |
| spike_i | input | 1 | Presynaptic spike for this cycle |
| weight_i | input | DATA_W | Signed synaptic weight |
| thresh_i | input | DATA_W | Signed firing threshold |
| reset_val_i | input | DATA_W | Signed value loaded after a spike |
| spike_o | output | 1 | Output spike, registered |
| vmem_o | output | DATA_W | Current membrane potential |

## Verification
The assertions check these rules on every cycle:
- a potential with no presynaptic spike holds its value;
- a firing evaluation always leaves the restart value and a spike behind it;
- a non-firing evaluation leaves neither;
- an accumulate cycle never produces a spike;
- the potential never wraps: a positive weight cannot lower it and a negative weight cannot raise it;
- clear wins over every other command.

Only the bench scenarios show the following:
- the exact clamped values at both rails;
- the boundary where the potential equals the threshold;
- signed comparisons against negative thresholds;
- a non-zero restart value;
- the precise potential reached after a chain of mixed-sign weights.

// File: rtl/ifn_pkg.sv
package ifn_pkg;

  localparam int IFN_DATA_W = 10;

  typedef enum logic {
    PH_EVAL  = 1'b0,
    PH_ACCUM = 1'b1
  } ifn_phase_e;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_ADD   = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } ifn_act_e;

endpackage

// File: rtl/ifn_sat_add.sv
module ifn_sat_add #(
  parameter int DATA_W = ifn_pkg::IFN_DATA_W
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [DATA_W-1:0] sum_o
);
  localparam int EXT_W = DATA_W + 1;
  localparam logic signed [DATA_W-1:0] POS_RAIL = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] NEG_RAIL = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [EXT_W-1:0] wide;
  logic                    ovf;

  // One guard bit; overflow shows as disagreement of the top two bits.
  assign wide = EXT_W'(a_i) + EXT_W'(b_i);
  assign ovf  = wide[EXT_W-1] ^ wide[EXT_W-2];

  always_comb begin
    if (!ovf)
      sum_o = wide[DATA_W-1:0];
    else if (wide[EXT_W-1])
      sum_o = NEG_RAIL;
    else
      sum_o = POS_RAIL;
  end
endmodule

// File: rtl/ifn_thresh_cmp.sv
module ifn_thresh_cmp #(
  parameter int DATA_W = ifn_pkg::IFN_DATA_W
) (
  input  logic signed [DATA_W-1:0] vmem_i,
  input  logic signed [DATA_W-1:0] thresh_i,
  output logic                     above_o
);
  // Strictly greater: equality does not fire.
  assign above_o = (vmem_i > thresh_i);
endmodule

// File: rtl/ifn_ctrl.sv
module ifn_ctrl
  import ifn_pkg::*;
(
  input  logic       clr_i,
  input  ifn_phase_e phase_i,
  input  logic       spike_i,
  input  logic       above_i,
  output ifn_act_e   act_o,
  output logic       fire_o
);
  always_comb begin
    act_o = ACT_HOLD;
    if (clr_i)
      act_o = ACT_CLEAR;
    else if (phase_i == PH_ACCUM)
      act_o = spike_i ? ACT_ADD : ACT_HOLD;
    else
      act_o = above_i ? ACT_LOAD : ACT_HOLD;
  end

  assign fire_o = (act_o == ACT_LOAD);
endmodule

// File: rtl/ifn_neuron.sv
module ifn_neuron
  import ifn_pkg::*;
#(
  parameter int DATA_W = IFN_DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     mode_i,
  input  logic                     spike_i,
  input  logic signed [DATA_W-1:0] weight_i,
  input  logic signed [DATA_W-1:0] thresh_i,
  input  logic signed [DATA_W-1:0] reset_val_i,
  output logic                     spike_o,
  output logic signed [DATA_W-1:0] vmem_o
);
  logic signed [DATA_W-1:0] vmem_q;
  logic signed [DATA_W-1:0] vmem_d;
  logic signed [DATA_W-1:0] acc_sum;
  logic                     above;
  logic                     fire;
  logic                     spike_q;
  ifn_act_e                 act;
  ifn_phase_e               phase;

  assign phase = ifn_phase_e'(mode_i);

  ifn_sat_add #(.DATA_W(DATA_W)) u_add (
    .a_i   (vmem_q),
    .b_i   (weight_i),
    .sum_o (acc_sum)
  );

  ifn_thresh_cmp #(.DATA_W(DATA_W)) u_cmp (
    .vmem_i   (vmem_q),
    .thresh_i (thresh_i),
    .above_o  (above)
  );

  ifn_ctrl u_ctrl (
    .clr_i   (clr_i),
    .phase_i (phase),
    .spike_i (spike_i),
    .above_i (above),
    .act_o   (act),
    .fire_o  (fire)
  );

  always_comb begin
    case (act)
      ACT_ADD:   vmem_d = acc_sum;
      ACT_LOAD:  vmem_d = reset_val_i;
      ACT_CLEAR: vmem_d = '0;
      default:   vmem_d = vmem_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vmem_q  <= '0;
      spike_q <= 1'b0;
    end else begin
      vmem_q  <= vmem_d;
      spike_q <= fire;
    end
  end

  assign vmem_o  = vmem_q;
  assign spike_o = spike_q;
endmodule

// File: rtl/ifn_neuron_chk.sv
module ifn_neuron_chk #(
  parameter int DATA_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr_i,
  input logic                     mode_i,
  input logic                     spike_i,
  input logic signed [DATA_W-1:0] weight_i,
  input logic signed [DATA_W-1:0] thresh_i,
  input logic signed [DATA_W-1:0] reset_val_i,
  input logic                     spike_o,
  input logic signed [DATA_W-1:0] vmem_o
);
  // R3: no presynaptic spike, no change
  a_r3_hold_without_spike: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && mode_i && !spike_i) |=> $stable(vmem_o));

  // R4: firing leaves spike and restart value
  a_r4_fire_loads_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !mode_i && (vmem_o > thresh_i)) |=> (spike_o && vmem_o == $past(reset_val_i)));

  // R5: a non-firing evaluation keeps state and stays quiet
  a_r5_no_fire_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !mode_i && !(vmem_o > thresh_i)) |=> (!spike_o && $stable(vmem_o)));

  // R6: no wrap on a positive weight
  a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && mode_i && spike_i && weight_i >= 0) |=> (vmem_o >= $past(vmem_o)));

  // R6: no wrap on a negative weight
  a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && mode_i && spike_i && weight_i < 0) |=> (vmem_o <= $past(vmem_o)));

  // R7: an accumulate cycle never yields a spike
  a_r7_accum_no_spike: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i |=> !spike_o);

  // R8: clear dominates
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (vmem_o == 0 && !spike_o));

  // R1: reset state
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_state: assert (vmem_o == 0 && !spike_o);
    end
  end
endmodule

bind ifn_neuron ifn_neuron_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .mode_i      (mode_i),
  .spike_i     (spike_i),
  .weight_i    (weight_i),
  .thresh_i    (thresh_i),
  .reset_val_i (reset_val_i),
  .spike_o     (spike_o),
  .vmem_o      (vmem_o)
);

// File: tb/ifn_neuron_tb.sv
module ifn_neuron_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 10;
  localparam int VMAX       = (1 << (W-1)) - 1;
  localparam int VMIN       = -(1 << (W-1));

  typedef struct {
    int    vmem;
    bit    spike;
    string tag;
  } exp_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                clr_i = 1'b0;
  logic                mode_i = 1'b1;
  logic                spike_i = 1'b0;
  logic signed [W-1:0] weight_i = '0;
  logic signed [W-1:0] thresh_i = '0;
  logic signed [W-1:0] reset_val_i = '0;
  logic                spike_o;
  logic signed [W-1:0] vmem_o;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   model_v  = 0;
  bit   done     = 1'b0;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ifn_neuron #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .mode_i(mode_i), .spike_i(spike_i),
    .weight_i(weight_i), .thresh_i(thresh_i), .reset_val_i(reset_val_i),
    .spike_o(spike_o), .vmem_o(vmem_o)
  );

  function automatic int clamp(input int x);
    if (x > VMAX) return VMAX;
    if (x < VMIN) return VMIN;
    return x;
  endfunction

  // Monitor: compare one expectation just after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (int'(vmem_o) != e.vmem || spike_o != e.spike) begin
        n_fail++;
        $display("FAIL %s: vmem=%0d spike=%0b expected vmem=%0d spike=%0b",
                 e.tag, int'(vmem_o), spike_o, e.vmem, e.spike);
      end
    end
  end

  // Driver: apply one command at the falling edge, push its expected outcome
  task automatic step(input bit mode, input bit spk, input int w, input int thr,
                      input int rv, input bit clr, input string tag);
    exp_t e;
    @(negedge clk);
    mode_i      = mode;
    spike_i     = spk;
    weight_i    = W'(w);
    thresh_i    = W'(thr);
    reset_val_i = W'(rv);
    clr_i       = clr;
    e.tag   = tag;
    e.spike = 1'b0;
    if (clr) model_v = 0;
    else if (mode) begin
      if (spk) model_v = clamp(model_v + w);
    end else if (model_v > thr) begin
      e.spike = 1'b1;
      model_v = rv;
    end
    e.vmem = model_v;
    sb_q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    n_checks++;
    if (vmem_o != 0 || spike_o != 1'b0) begin
      n_fail++;
      $display("FAIL R1: vmem=%0d spike=%0b expected vmem=0 spike=0", int'(vmem_o), spike_o);
    end
    rst_n = 1'b1;
    step(1, 0, 0, 100, 0, 0, "R1 first cycle");
    step(1, 1, 40, 100, 0, 0, "R2 add");
    step(1, 1, 50, 100, 0, 0, "R2 add second");
    step(1, 0, 77, 100, 0, 0, "R3 hold");
    step(0, 0, 0, 100, 0, 0, "R5 below");
    step(1, 1, 10, 100, 0, 0, "R2 reach threshold");
    step(0, 0, 0, 100, 0, 0, "R5 equal");
    step(1, 1, 1, 100, 0, 0, "R2 above");
    step(0, 0, 0, 100, 0, 0, "R4 fire");
    step(0, 0, 0, 100, 0, 0, "R7 single cycle");
    step(1, 1, -30, 100, 0, 0, "R9 negative weight");
    step(0, 0, 0, -40, -5, 0, "R10 restart value");
    step(1, 1, 300, 0, 0, 0, "R7 accum after fire");
    step(1, 1, 300, 0, 0, 0, "R6 positive rail");
    step(1, 1, 1, 0, 0, 0, "R6 stay at rail");
    step(1, 1, -300, 0, 0, 0, "R6 down");
    step(1, 1, -300, 0, 0, 0, "R6 down");
    step(1, 1, -300, 0, 0, 0, "R6 down");
    step(1, 1, -300, 0, 0, 0, "R6 negative rail");
    step(0, 0, 0, -512, 0, 0, "R9 equal at negative rail");
    step(1, 1, 100, 0, 0, 1, "R8 clear in accumulate");
    step(1, 1, 50, 10, 0, 0, "R2 before clear");
    step(0, 0, 0, 10, 7, 1, "R8 clear over fire");
    step(0, 0, 0, -1, 0, 0, "R9 zero above minus one");
    step(0, 0, 0, -1, 0, 0, "R10 zero restart holds");
    for (int i = 0; i < 400; i++) begin
      bit m;
      bit s;
      bit c;
      m = bit'($urandom_range(0, 1));
      s = bit'($urandom_range(0, 1));
      c = ($urandom_range(0, 31) == 0);
      step(m, s, $urandom_range(0, 1023) - 512, $urandom_range(0, 1023) - 512,
           $urandom_range(0, 1023) - 512, c, "R2 R4 mixed");
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule